// File: doc/BRIEF.md
# Self-Synchronizing Parallel PRBS Checker

This block compares a received parallel data word against a selectable pseudo-random binary sequence, one word on every edge of the receive user clock. It does not run a free-running reference generator. It keeps the most recent 31 received bits as generator state. From that state it unrolls the sequence polynomial across the word width to predict the next word. Because the state is refilled from received data every cycle, the checker locks to any phase of the incoming sequence after one word. A corrupted bit that enters the state also corrupts the following prediction, so a single bit flip can be flagged on two consecutive words.

A 3-bit mode input selects one of four polynomials, or turns checking off. The block reports mismatches two ways. A registered per-word error flag goes high for each bad word and is not sticky. A 16-bit saturating counter adds one for every word that holds at least one wrong bit, and a synchronous clear input resets it. A loopback select chooses what drives the transmit force-error output: either the error flag, or an external force-error input passed straight through.

Internally, a two-state tracking machine decides when a word is compared. In IDLE no PRBS mode is selected. In TRACK the state register holds history captured under the current mode. The machine has four transitions:
- ENTER (IDLE to TRACK): a valid mode appears.
- RESEED (TRACK to TRACK): the mode value changes.
- HOLD (TRACK to TRACK): the mode is unchanged.
- LEAVE (TRACK to IDLE): the mode becomes off or invalid.

Only a HOLD cycle compares the word.

Top module: `prbs_rx_check`

## Requirements
- R1: Mode codes are 3'b001 for PRBS-7 (x^7+x^6+1), 3'b010 for PRBS-15 (x^15+x^14+1), 3'b011 for PRBS-23 (x^23+x^18+1) and 3'b100 for PRBS-31 (x^31+x^28+1). `data_i[0]` is the earliest bit of the word in sequence time, and bit k obeys s[k] = s[k-N] xor s[k-T]. A clean sequence in any of these modes raises no error after the seed word.
- R2: With mode 3'b000 or any of 3'b101..3'b111, `err_o` is low for that word and `err_cnt_o` does not advance.
- R3: The first word after reset, and the first word after any change of `mode_i`, seeds the state and is never compared: `err_o` stays low and the counter does not advance for that word.
- R4: `err_o` is registered. It is high in the cycle after the clock edge that sampled a mismatching word, and low after an edge that sampled a matching word (not sticky).
- R5: State is rebuilt from received data. A single flipped bit at position p of a word flags that word. It also flags the next word when p >= W-N, where W is the word width and N the polynomial length; otherwise only the one word is flagged.
- R6: The counter increases by exactly 1 per mismatching word, whatever the number of wrong bits in it, and is updated on the same edge as `err_o`.
- R7: The counter saturates at 16'hFFFF and holds there.
- R8: `cnt_clr_i` clears the counter on the next edge and takes priority over an increment on that edge.
- R9: `tx_force_o` equals `err_o` when `lb_en_i` is 1, and equals `tx_force_i` when it is 0.
- R10: During and right after reset, `err_o` is 0 and `err_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | receive user clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| mode_i | input | 3 | pattern select (R1 codes, others off) |
| data_i | input | DATA_W | received word, bit 0 earliest |
| cnt_clr_i | input | 1 | synchronous error counter clear |
| lb_en_i | input | 1 | route error flag to transmit force-error |
| tx_force_i | input | 1 | external transmit force-error request |
| err_o | output | 1 | word mismatch flag, registered |
| err_cnt_o | output | CNT_W | saturating count of bad words |
| tx_force_o | output | 1 | transmit force-error output |

## Verification
`err_o` and `err_cnt_o` both reflect the word presented before a given rising edge, and both are visible right after that edge. `tx_force_o` follows `err_o` with no further register. The bench drives each word at a falling edge and advances its reference model for that word. It then waits for the rising edge and compares all three outputs at the next falling edge, so every comparison lands exactly one edge after its stimulus. Burst lengths are counted across the words that follow an injected flip, and the clear-priority case puts a clear and a bad word on the same edge.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    // Longest polynomial sets the depth of retained history.
    localparam int HIST_W   = 31;
    localparam int NUM_POLY = 4;
    localparam int SEL_W    = $clog2(NUM_POLY);

    localparam logic [2:0] MODE_OFF = 3'b000;
    localparam logic [2:0] MODE_P7  = 3'b001;
    localparam logic [2:0] MODE_P31 = 3'b100;

    typedef enum logic {
        ST_IDLE,
        ST_TRACK
    } trk_state_e;

    function automatic int poly_len(input int p);
        case (p)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int poly_tap(input int p);
        case (p)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

    function automatic logic mode_valid(input logic [2:0] m);
        return (m >= MODE_P7) && (m <= MODE_P31);
    endfunction

    function automatic logic [SEL_W-1:0] mode_sel(input logic [2:0] m);
        logic [2:0] d;
        d = m - 3'd1;
        return d[SEL_W-1:0];
    endfunction

endpackage

// File: rtl/prbs_expect.sv
module prbs_expect
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [HIST_W-1:0] hist_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [2:0]        mode_i,
    output logic [DATA_W-1:0] exp_o,
    output logic [HIST_W-1:0] hist_next_o
);

    localparam int SEQ_W = HIST_W + DATA_W;

    logic [NUM_POLY-1:0][DATA_W-1:0] cand;
    logic [SEQ_W-1:0]                recv_seq;

    // One unrolled generator per polynomial; the mode picks one word.
    for (genvar p = 0; p < NUM_POLY; p++) begin : g_poly
        localparam int N = poly_len(p);
        localparam int T = poly_tap(p);
        logic [SEQ_W-1:0] seq;

        always_comb begin
            seq = '0;
            seq[HIST_W-1:0] = hist_i;
            for (int i = 0; i < DATA_W; i++) begin
                seq[HIST_W+i] = seq[HIST_W+i-N] ^ seq[HIST_W+i-T];
            end
        end

        assign cand[p] = seq[SEQ_W-1:HIST_W];
    end

    assign exp_o = cand[mode_sel(mode_i)];

    // Time-ordered concatenation: history oldest, new word latest.
    assign recv_seq    = {data_i, hist_i};
    assign hist_next_o = recv_seq[SEQ_W-1 -: HIST_W];

endmodule

// File: rtl/prbs_track_fsm.sv
module prbs_track_fsm
    import prbs_chk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] mode_i,
    output logic       cmp_en_o
);

    trk_state_e state_q, state_d;
    logic [2:0] mode_q;
    logic       valid;
    logic       same;

    assign valid = mode_valid(mode_i);
    assign same  = (mode_i == mode_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_OFF;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
        end
    end

    always_comb begin
        state_d  = state_q;
        cmp_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (valid) begin
                    state_d = ST_TRACK;   // ENTER: seed only
                end
            end
            ST_TRACK: begin
                if (!valid) begin
                    state_d = ST_IDLE;    // LEAVE
                end else if (same) begin
                    cmp_en_o = 1'b1;      // HOLD: compare
                end
                // RESEED: valid, changed mode, stay and seed
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/prbs_err_stat.sv
module prbs_err_stat #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmp_en_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic              clr_i,
    output logic              err_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hit;
    logic err_q;
    logic [CNT_W-1:0] cnt_q;

    assign hit = cmp_en_i && (data_i != exp_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            err_q <= hit;
            if (clr_i) begin
                cnt_q <= '0;
            end else if (hit && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign err_o = err_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/prbs_rx_check.sv
module prbs_rx_check
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              cnt_clr_i,
    input  logic              lb_en_i,
    input  logic              tx_force_i,
    output logic              err_o,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic              tx_force_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_next;
    logic [DATA_W-1:0] exp_word;
    logic              cmp_en;

    // History is refilled from received data on every edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_next;
        end
    end

    prbs_expect #(.DATA_W(DATA_W)) u_expect (
        .hist_i      (hist_q),
        .data_i      (data_i),
        .mode_i      (mode_i),
        .exp_o       (exp_word),
        .hist_next_o (hist_next)
    );

    prbs_track_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode_i),
        .cmp_en_o (cmp_en)
    );

    prbs_err_stat #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stat (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cmp_en_i (cmp_en),
        .data_i   (data_i),
        .exp_i    (exp_word),
        .clr_i    (cnt_clr_i),
        .err_o    (err_o),
        .cnt_o    (err_cnt_o)
    );

    assign tx_force_o = lb_en_i ? err_o : tx_force_i;

endmodule

// File: rtl/prbs_rx_check_sva.sv
module prbs_rx_check_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       mode_i,
    input logic             cnt_clr_i,
    input logic             err_o,
    input logic [CNT_W-1:0] err_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic mode_ok;
    assign mode_ok = (mode_i >= 3'd1) && (mode_i <= 3'd4);

    assert_off_no_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_ok |=> !err_o);

    assert_off_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_ok && !cnt_clr_i) |=> $stable(err_cnt_o));

    assert_seed_no_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != $past(mode_i)) |=> !err_o);

    assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_clr_i |=> ((err_cnt_o == $past(err_cnt_o)) ||
                        (err_cnt_o == $past(err_cnt_o) + 1'b1)));

    assert_count_tracks_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_clr_i && (err_cnt_o != CNT_MAX)) |=>
            (err_o == (err_cnt_o != $past(err_cnt_o))));

    assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_clr_i && (err_cnt_o == CNT_MAX)) |=> (err_cnt_o == CNT_MAX));

    assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_clr_i |=> (err_cnt_o == '0));

endmodule

bind prbs_rx_check prbs_rx_check_sva #(.CNT_W(CNT_W)) u_sva (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .cnt_clr_i (cnt_clr_i),
    .err_o     (err_o),
    .err_cnt_o (err_cnt_o)
);

// File: tb/prbs_rx_check_bench.sv
module prbs_rx_check_bench;

    localparam int W          = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   mode;
    logic [W-1:0] data;
    logic         cnt_clr;
    logic         lb_en;
    logic         tx_force;
    logic         err_o;
    logic [15:0]  err_cnt_o;
    logic         tx_force_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_rx_check #(.DATA_W(W), .CNT_W(16)) u_prbs_rx_check (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .data_i     (data),
        .cnt_clr_i  (cnt_clr),
        .lb_en_i    (lb_en),
        .tx_force_i (tx_force),
        .err_o      (err_o),
        .err_cnt_o  (err_cnt_o),
        .tx_force_o (tx_force_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    bit       gq[$];   // transmitted bit stream
    bit       rq[$];   // received history for the model
    bit       m_run;
    bit [2:0] m_mode;
    bit       m_err;
    int       m_cnt;
    int       burst;

    function automatic int plen(input bit [2:0] m);
        case (m)
            3'd1:    return 7;
            3'd2:    return 15;
            3'd3:    return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int ptap(input bit [2:0] m);
        case (m)
            3'd1:    return 6;
            3'd2:    return 14;
            3'd3:    return 18;
            default: return 28;
        endcase
    endfunction

    function automatic logic [W-1:0] gen_word(input bit [2:0] m);
        logic [W-1:0] w;
        int n = plen(m);
        int t = ptap(m);
        for (int i = 0; i < W; i++) begin
            bit b;
            b = gq[gq.size()-n] ^ gq[gq.size()-t];
            gq.push_back(b);
            w[i] = b;
        end
        while (gq.size() > 64) void'(gq.pop_front());
        return w;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] d, input bit [2:0] m, input bit clr, input string tag);
        bit valid;
        bit cmp;
        bit mism;
        bit h[$];
        data    = d;
        mode    = m;
        cnt_clr = clr;
        valid = (m >= 3'd1) && (m <= 3'd4);
        cmp   = valid && m_run && (m == m_mode);
        mism  = 1'b0;
        if (cmp) begin
            int n = plen(m);
            int t = ptap(m);
            h = rq;
            for (int i = 0; i < W; i++) begin
                bit e;
                e = h[h.size()-n] ^ h[h.size()-t];
                h.push_back(e);
                if (e != d[i]) mism = 1'b1;
            end
        end
        for (int i = 0; i < W; i++) rq.push_back(d[i]);
        while (rq.size() > 31) void'(rq.pop_front());
        m_run  = valid;
        m_mode = m;
        m_err  = mism;
        if (clr) m_cnt = 0;
        else if (mism && m_cnt < 65535) m_cnt++;
        @(posedge clk);
        @(negedge clk);
        check(tag, "err_o", int'(err_o), int'(m_err));
        check(tag, "err_cnt_o", int'(err_cnt_o), m_cnt);
        check("R9", "tx_force_o", int'(tx_force_o), lb_en ? int'(m_err) : int'(tx_force));
        if (err_o) burst++;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        mode    = 3'd0;
        data    = '0;
        cnt_clr = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R10", "err_o in reset", int'(err_o), 0);
        check("R10", "err_cnt_o in reset", int'(err_cnt_o), 0);
        rst_n  = 1'b1;
        m_run  = 1'b0;
        m_mode = 3'd0;
        m_err  = 1'b0;
        m_cnt  = 0;
        rq.delete();
        for (int i = 0; i < 31; i++) rq.push_back(1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R10", "err_o after reset", int'(err_o), 0);
        check("R10", "err_cnt_o after reset", int'(err_cnt_o), 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            errors++;
            $display("FAIL R1 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w;
        lb_en    = 1'b0;
        tx_force = 1'b1;
        do_reset();
        check("R9", "tx passthrough", int'(tx_force_o), 1);
        tx_force = 1'b0;
        for (int i = 0; i < 31; i++) gq.push_back(bit'((i % 3) == 0));

        // Clean sequences in every mode; first word of each is a seed (R3).
        for (int m = 1; m <= 4; m++) begin
            step(gen_word(3'(m)), 3'(m), 1'b0, "R3");
            for (int k = 0; k < 40; k++) step(gen_word(3'(m)), 3'(m), 1'b0, "R1");
        end
        check("R1", "no errors on clean data", int'(err_cnt_o), 0);

        // Off and invalid modes with junk data.
        for (int m = 0; m < 8; m++) begin
            if (m == 0 || m > 4) begin
                for (int k = 0; k < 6; k++) step(W'(32'hA5C3_0000 + k * 977), 3'(m), 1'b0, "R2");
            end
        end
        check("R2", "counter held while off", int'(err_cnt_o), 0);

        // Entry after junk: the seed word would mismatch if compared.
        step(gen_word(3'd2), 3'd2, 1'b0, "R3");
        for (int k = 0; k < 10; k++) step(gen_word(3'd2), 3'd2, 1'b0, "R1");
        check("R3", "seed after junk not counted", int'(err_cnt_o), 0);

        // Single-bit flip in the tail of a PRBS-7 word: two-word burst.
        lb_en = 1'b1;
        step(gen_word(3'd1), 3'd1, 1'b0, "R3");
        for (int k = 0; k < 5; k++) step(gen_word(3'd1), 3'd1, 1'b0, "R1");
        burst = 0;
        w = gen_word(3'd1);
        step(w ^ (W'(1) << (W-1)), 3'd1, 1'b0, "R5");
        for (int k = 0; k < 4; k++) step(gen_word(3'd1), 3'd1, 1'b0, "R4");
        check("R5", "burst length tail flip", burst, 2);
        check("R6", "count after tail flip", int'(err_cnt_o), 2);

        // Flip in the head of a word: one word only.
        lb_en    = 1'b0;
        tx_force = 1'b1;
        burst = 0;
        w = gen_word(3'd1);
        step(w ^ W'(1), 3'd1, 1'b0, "R5");
        for (int k = 0; k < 4; k++) step(gen_word(3'd1), 3'd1, 1'b0, "R4");
        check("R5", "burst length head flip", burst, 1);

        // Five wrong bits in one word count once.
        w = gen_word(3'd1);
        step(w ^ W'(32'h1F), 3'd1, 1'b0, "R6");
        check("R6", "multi-bit word counted once", int'(err_cnt_o), 4);
        step(gen_word(3'd1), 3'd1, 1'b0, "R4");
        check("R4", "flag drops on good word", int'(err_o), 0);

        // PRBS-31: bit 0 is outside the state window, bit 1 is inside.
        tx_force = 1'b0;
        step(gen_word(3'd4), 3'd4, 1'b0, "R3");
        step(gen_word(3'd4), 3'd4, 1'b0, "R1");
        burst = 0;
        w = gen_word(3'd4);
        step(w ^ W'(1), 3'd4, 1'b0, "R5");
        for (int k = 0; k < 3; k++) step(gen_word(3'd4), 3'd4, 1'b0, "R5");
        check("R5", "PRBS-31 bit0 burst", burst, 1);
        burst = 0;
        w = gen_word(3'd4);
        step(w ^ W'(2), 3'd4, 1'b0, "R5");
        for (int k = 0; k < 3; k++) step(gen_word(3'd4), 3'd4, 1'b0, "R5");
        check("R5", "PRBS-31 bit1 burst", burst, 2);

        // Clear alone.
        step(gen_word(3'd4), 3'd4, 1'b1, "R8");
        check("R8", "clear", int'(err_cnt_o), 0);

        // Saturation: all-ones words never match PRBS-7.
        for (int k = 0; k < 65540; k++) step('1, 3'd1, 1'b0, "R7");
        check("R7", "saturated", int'(err_cnt_o), 65535);
        step('1, 3'd1, 1'b0, "R7");
        check("R7", "holds at max", int'(err_cnt_o), 65535);

        // Clear and a bad word on the same edge.
        step('1, 3'd1, 1'b1, "R8");
        check("R8", "clear beats increment", int'(err_cnt_o), 0);
        check("R8", "flag still raised", int'(err_o), 1);
        step('1, 3'd1, 1'b0, "R6");
        check("R6", "counts again after clear", int'(err_cnt_o), 1);

        summary();
        $finish;
    end

endmodule